// File: doc/BRIEF.md
# Framed Stack Register File

This block is the operand store of a stack-oriented datapath. Storage is split into several equal call frames and one small global frame for state that does not belong to any call. Each location is named by a frame number and a word offset inside that frame. Frames `0` to `NUM_FRAMES-1` are the call frames. Frame number `NUM_FRAMES` is the global frame.

A single read port returns two words at once: the word at the given offset and the word one offset below it in the same frame. These are the two top-of-stack operands. They are steered onto two operand buses, and a swap input exchanges them. Each bus takes register-file data only when its source select is zero. Any other select value hands the bus to another unit, so the block drives zero there.

One result word is written per cycle. A burst mode writes the same result into eight aligned consecutive words, which lets a call clear or preset its variable area in a single cycle. Reads and writes are synchronous to one clock. Read data appears one cycle after the address.

Top module: `stack_frame_rf`

## Requirements
- R1: While reset is active, and after it is released, both operand buses and the error flag are zero. Every storage word reads as zero until it is written.
- R2: Operand results are registered. In the cycle after a read address is presented, bus 1 holds the word at (frame, offset) and bus 2 holds the word at (frame, offset-1).
- R3: With the swap input high, bus 1 holds the word at offset-1 and bus 2 holds the word at the given offset.
- R4: A read at offset 0 gives zero for the offset-1 word. It never wraps into another frame.
- R5: A write needs all three of the following: the write permit is high, the combined write address {frame, offset} is nonzero, and burst mode is off. The result word is then stored at the clock edge. Frame 0 offset 0 can therefore never be written.
- R6: In burst mode, with a valid aligned start (offset bits [2:0] zero) and offset+8 within the frame size, all eight words from offset to offset+7 take the result value.
- R7: In burst mode, with the write permit high and a nonzero address, a start that is misaligned, overruns the frame, or is invalid stores nothing. The error flag is then high in exactly the following cycle.
- R8: A read of a word that is written in the same cycle returns its old contents.
- R9: A frame number above `NUM_FRAMES`, or an offset at or beyond the frame's size, reads as zero on both words and drops single writes.
- R10: A nonzero source select on bus 1 (or bus 2) forces that bus to zero in the following cycle.
- R11: Frame number `NUM_FRAMES` is the global frame. It has `GLOBAL_WORDS` words. The call frames have `FRAME_WORDS` words each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_frame | input | FRM_W | Read frame number |
| rd_off | input | OFF_W | Read word offset |
| rd_swap | input | 1 | Exchange the two read words between the buses |
| src1_sel | input | SRC_W | Bus 1 source select; zero selects the register file |
| src2_sel | input | SRC_W | Bus 2 source select; zero selects the register file |
| wr_frame | input | FRM_W | Write frame number |
| wr_off | input | OFF_W | Write word offset |
| wr_ok | input | 1 | Write permit |
| wr_octal | input | 1 | Eight-word burst write mode |
| res_bus | input | WORD_W | Result word to store |
| op1 | output | WORD_W | Operand bus 1 |
| op2 | output | WORD_W | Operand bus 2 |
| oct_err | output | 1 | One-cycle flag for a rejected burst write |

## Verification
A corrupted storage word stays hidden until it is read. It then shows up on one of the two operand buses one cycle after its address is presented. Because every read also fetches the word below, a fault is exposed by reads at either of two neighbouring offsets. A bad burst-write decision shows up in two places. Missing or extra words appear on later reads. The error flag itself is wrong in the very next cycle. The reference model therefore compares both buses and the flag on every clock. Its reads sweep the neighbours of every written location.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int OCT_LEN        = 8;
    localparam int OCT_ALIGN_BITS = 3;
endpackage

// File: rtl/rf_addr_dec.sv
module rf_addr_dec #(
    parameter int NUM_FRAMES   = 4,
    parameter int FRAME_WORDS  = 40,
    parameter int GLOBAL_WORDS = 10,
    parameter int FRM_W        = 3,
    parameter int OFF_W        = 6,
    parameter int IDX_W        = 8
) (
    input  logic [FRM_W-1:0] frame,
    input  logic [OFF_W-1:0] off,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic             has_below,
    output logic             oct_fit
);
    import rf_pkg::*;

    int size;

    always_comb begin
        size      = (int'(frame) == NUM_FRAMES) ? GLOBAL_WORDS : FRAME_WORDS;
        valid     = (int'(frame) <= NUM_FRAMES) && (int'(off) < size);
        idx       = valid ? IDX_W'(int'(frame) * FRAME_WORDS + int'(off)) : '0;
        has_below = valid && (off != '0);
        oct_fit   = valid && (off[OCT_ALIGN_BITS-1:0] == '0)
                    && (int'(off) + OCT_LEN <= size);
    end
endmodule

// File: rtl/rf_route.sv
module rf_route #(
    parameter int WORD_W = 34,
    parameter int SRC_W  = 3
) (
    input  logic [WORD_W-1:0] upper,
    input  logic [WORD_W-1:0] lower,
    input  logic              swap,
    input  logic [SRC_W-1:0]  sel1,
    input  logic [SRC_W-1:0]  sel2,
    output logic [WORD_W-1:0] d1,
    output logic [WORD_W-1:0] d2
);
    always_comb begin
        d1 = '0;
        d2 = '0;
        if (sel1 == '0) d1 = swap ? lower : upper;
        if (sel2 == '0) d2 = swap ? upper : lower;
    end
endmodule

// File: rtl/stack_frame_rf.sv
module stack_frame_rf #(
    parameter int NUM_FRAMES   = 4,
    parameter int FRAME_WORDS  = 40,
    parameter int GLOBAL_WORDS = 10,
    parameter int WORD_W       = 34,
    parameter int SRC_W        = 3,
    parameter int FRM_W        = $clog2(NUM_FRAMES + 1),
    parameter int OFF_W        = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRM_W-1:0]  rd_frame,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic              rd_swap,
    input  logic [SRC_W-1:0]  src1_sel,
    input  logic [SRC_W-1:0]  src2_sel,
    input  logic [FRM_W-1:0]  wr_frame,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic              wr_ok,
    input  logic              wr_octal,
    input  logic [WORD_W-1:0] res_bus,
    output logic [WORD_W-1:0] op1,
    output logic [WORD_W-1:0] op2,
    output logic              oct_err
);
    import rf_pkg::*;

    localparam int DEPTH = NUM_FRAMES * FRAME_WORDS + GLOBAL_WORDS;
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct {
        logic [WORD_W-1:0] mem [DEPTH];
        logic [WORD_W-1:0] op1;
        logic [WORD_W-1:0] op2;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    // port 0 = read, port 1 = write
    logic [1:0][FRM_W-1:0] dec_frame;
    logic [1:0][OFF_W-1:0] dec_off;
    logic [1:0]            dec_valid, dec_below, dec_fit;
    logic [IDX_W-1:0]      dec_idx [2];

    assign dec_frame[0] = rd_frame;
    assign dec_off[0]   = rd_off;
    assign dec_frame[1] = wr_frame;
    assign dec_off[1]   = wr_off;

    for (genvar p = 0; p < 2; p++) begin : g_dec
        rf_addr_dec #(
            .NUM_FRAMES  (NUM_FRAMES),
            .FRAME_WORDS (FRAME_WORDS),
            .GLOBAL_WORDS(GLOBAL_WORDS),
            .FRM_W       (FRM_W),
            .OFF_W       (OFF_W),
            .IDX_W       (IDX_W)
        ) u_dec (
            .frame    (dec_frame[p]),
            .off      (dec_off[p]),
            .valid    (dec_valid[p]),
            .idx      (dec_idx[p]),
            .has_below(dec_below[p]),
            .oct_fit  (dec_fit[p])
        );
    end

    logic [WORD_W-1:0] rd_upper, rd_lower, bus1_d, bus2_d;
    logic              wr_en;

    always_comb begin
        rd_upper = dec_valid[0] ? st_q.mem[dec_idx[0]] : '0;
        rd_lower = dec_below[0] ? st_q.mem[dec_idx[0] - IDX_W'(1)] : '0;
    end

    rf_route #(.WORD_W(WORD_W), .SRC_W(SRC_W)) u_route (
        .upper(rd_upper),
        .lower(rd_lower),
        .swap (rd_swap),
        .sel1 (src1_sel),
        .sel2 (src2_sel),
        .d1   (bus1_d),
        .d2   (bus2_d)
    );

    assign wr_en = wr_ok && ({wr_frame, wr_off} != '0);

    always_comb begin
        st_d     = st_q;
        st_d.op1 = bus1_d;
        st_d.op2 = bus2_d;
        st_d.err = 1'b0;
        if (wr_en) begin
            if (wr_octal) begin
                if (dec_fit[1]) begin
                    for (int k = 0; k < OCT_LEN; k++) begin
                        st_d.mem[dec_idx[1] + IDX_W'(k)] = res_bus;
                    end
                end else begin
                    st_d.err = 1'b1;
                end
            end else if (dec_valid[1]) begin
                st_d.mem[dec_idx[1]] = res_bus;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q.mem[i] <= '0;
            st_q.op1 <= '0;
            st_q.op2 <= '0;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op1     = st_q.op1;
    assign op2     = st_q.op2;
    assign oct_err = st_q.err;
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int NUM_FRAMES = 4,
    parameter int WORD_W     = 34,
    parameter int SRC_W      = 3,
    parameter int FRM_W      = 3,
    parameter int OFF_W      = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FRM_W-1:0]  rd_frame,
    input logic [OFF_W-1:0]  rd_off,
    input logic              rd_swap,
    input logic [SRC_W-1:0]  src1_sel,
    input logic [SRC_W-1:0]  src2_sel,
    input logic              wr_ok,
    input logic              wr_octal,
    input logic [WORD_W-1:0] op1,
    input logic [WORD_W-1:0] op2,
    input logic              oct_err
);
    AST_ERR_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        oct_err |-> $past(wr_octal && wr_ok)); // R7

    AST_BUS1_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(src1_sel != '0) |-> (op1 == '0)); // R10

    AST_BUS2_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(src2_sel != '0) |-> (op2 == '0)); // R10

    AST_NO_WRAP_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_off == '0 && !rd_swap && src2_sel == '0) |-> (op2 == '0)); // R4

    AST_NO_WRAP_SWAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_off == '0 && rd_swap && src1_sel == '0) |-> (op1 == '0)); // R4

    AST_BAD_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(int'(rd_frame) > NUM_FRAMES) |-> (op1 == '0 && op2 == '0)); // R9
endmodule

bind stack_frame_rf rf_checker #(
    .NUM_FRAMES(NUM_FRAMES),
    .WORD_W    (WORD_W),
    .SRC_W     (SRC_W),
    .FRM_W     (FRM_W),
    .OFF_W     (OFF_W)
) u_rf_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_frame(rd_frame),
    .rd_off  (rd_off),
    .rd_swap (rd_swap),
    .src1_sel(src1_sel),
    .src2_sel(src2_sel),
    .wr_ok   (wr_ok),
    .wr_octal(wr_octal),
    .op1     (op1),
    .op2     (op2),
    .oct_err (oct_err)
);

// File: tb/tb_stack_frame_rf.sv
module tb_stack_frame_rf;
    localparam int NF = 4, FW = 40, GW = 10, W = 34, SW = 3, FRW = 3, OFW = 6;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [FRW-1:0] rd_frame = '0, wr_frame = '0;
    logic [OFW-1:0] rd_off = '0, wr_off = '0;
    logic          rd_swap = 1'b0, wr_ok = 1'b0, wr_octal = 1'b0;
    logic [SW-1:0] src1_sel = '0, src2_sel = '0;
    logic [W-1:0]  res_bus = '0;
    logic [W-1:0]  op1, op2;
    logic          oct_err;

    int checks = 0, errors = 0;
    logic [W-1:0] ref_mem [0:7][0:63];

    always #10 clk = ~clk;

    stack_frame_rf dut (
        .clk(clk), .rst_n(rst_n), .rd_frame(rd_frame), .rd_off(rd_off),
        .rd_swap(rd_swap), .src1_sel(src1_sel), .src2_sel(src2_sel),
        .wr_frame(wr_frame), .wr_off(wr_off), .wr_ok(wr_ok),
        .wr_octal(wr_octal), .res_bus(res_bus),
        .op1(op1), .op2(op2), .oct_err(oct_err)
    );

    function automatic int fsize(int f);
        return (f == NF) ? GW : FW;
    endfunction

    function automatic bit in_range(int f, int o);
        return (f <= NF) && (o < fsize(f));
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(int f, int o, bit sw, int s1, int s2,
                        int wf, int wo, bit ok, bit oct, logic [W-1:0] val, string tag);
        logic [W-1:0] a, b, e1, e2;
        bit e_err;
        rd_frame = FRW'(f); rd_off = OFW'(o); rd_swap = sw;
        src1_sel = SW'(s1); src2_sel = SW'(s2);
        wr_frame = FRW'(wf); wr_off = OFW'(wo); wr_ok = ok; wr_octal = oct; res_bus = val;
        a = in_range(f, o) ? ref_mem[f][o] : '0;
        b = (in_range(f, o) && o > 0) ? ref_mem[f][o-1] : '0;
        e1 = (s1 != 0) ? '0 : (sw ? b : a);
        e2 = (s2 != 0) ? '0 : (sw ? a : b);
        e_err = 1'b0;
        if (ok && (wf != 0 || wo != 0)) begin
            if (oct) begin
                if (in_range(wf, wo) && (wo % 8 == 0) && (wo + 8 <= fsize(wf)))
                    for (int k = 0; k < 8; k++) ref_mem[wf][wo+k] = val;
                else e_err = 1'b1;
            end else if (in_range(wf, wo)) begin
                ref_mem[wf][wo] = val;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "op1", op1, e1);
        check(tag, "op2", op2, e2);
        check(tag, "oct_err", {{(W-1){1'b0}}, oct_err}, {{(W-1){1'b0}}, e_err});
    endtask

    task automatic rd(int f, int o, bit sw, string tag);
        step(f, o, sw, 0, 0, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic wr(int f, int o, logic [W-1:0] v, string tag);
        step(0, 0, 0, 0, 0, f, o, 1, 0, v, tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int f = 0; f < 8; f++)
            for (int o = 0; o < 64; o++) ref_mem[f][o] = '0;
        repeat (3) @(negedge clk);
        check("R1", "op1 in reset", op1, '0);
        check("R1", "op2 in reset", op2, '0);
        rst_n = 1'b1;
        rd(1, 7, 0, "R1");
        rd(4, 3, 0, "R1");

        // R2 basic pair read
        wr(1, 5, 34'h0_1111_2222, "R5");
        wr(1, 6, 34'h3_AAAA_5555, "R5");
        rd(1, 6, 0, "R2");
        rd(1, 7, 0, "R2");
        // R3 swap
        rd(1, 6, 1, "R3");
        // R4 offset zero
        wr(2, 0, 34'h2_0000_0001, "R5");
        rd(2, 0, 0, "R4");
        rd(2, 0, 1, "R4");
        rd(2, 1, 0, "R4");
        // R5 permit low and zero address
        step(0, 0, 0, 0, 0, 1, 6, 0, 0, 34'h1_2345_6789, "R5");
        rd(1, 6, 0, "R5");
        wr(0, 0, 34'h3_FFFF_FFFF, "R5");
        rd(0, 0, 0, "R5");
        rd(0, 1, 0, "R5");
        // R6 burst writes
        step(0, 0, 0, 0, 0, 2, 8, 1, 1, 34'h1_CAFE_F00D, "R6");
        for (int o = 7; o <= 17; o++) rd(2, o, 0, "R6");
        step(0, 0, 0, 0, 0, 3, 32, 1, 1, 34'h0_7777_0000, "R6");
        for (int o = 31; o <= 40; o++) rd(3, o, 0, "R6");
        // R7 rejected bursts
        step(0, 0, 0, 0, 0, 2, 19, 1, 1, 34'h2_DEAD_BEEF, "R7");
        rd(2, 19, 0, "R7");
        step(0, 0, 0, 0, 0, 4, 8, 1, 1, 34'h2_DEAD_BEEF, "R7");
        rd(4, 9, 0, "R7");
        step(0, 0, 0, 0, 0, 6, 0, 1, 1, 34'h2_DEAD_BEEF, "R7");
        step(0, 0, 0, 0, 0, 2, 19, 0, 1, 34'h2_DEAD_BEEF, "R7");
        // R8 read during write
        step(1, 6, 0, 0, 0, 1, 6, 1, 0, 34'h0_0BAD_0BAD, "R8");
        rd(1, 6, 0, "R8");
        // R9 out-of-range addresses
        wr(6, 3, 34'h1_5555_5555, "R9");
        rd(6, 3, 0, "R9");
        wr(1, 45, 34'h1_5555_5555, "R9");
        rd(1, 45, 0, "R9");
        wr(4, 10, 34'h1_5555_5555, "R9");
        rd(4, 10, 0, "R9");
        // R10 source selects
        step(1, 6, 0, 3, 0, 0, 0, 0, 0, '0, "R10");
        step(1, 6, 0, 0, 5, 0, 0, 0, 0, '0, "R10");
        step(1, 6, 1, 7, 1, 0, 0, 0, 0, '0, "R10");
        // R11 global frame
        step(0, 0, 0, 0, 0, 4, 0, 1, 1, 34'h0_1357_9BDF, "R11");
        wr(4, 9, 34'h3_0246_8ACE, "R11");
        for (int o = 0; o <= 10; o++) rd(4, o, 0, "R11");
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            bit oct;
            int wo;
            oct = ($urandom_range(0, 3) == 0);
            wo  = oct ? 8 * $urandom_range(0, 5) + (($urandom_range(0, 5) == 0) ? 2 : 0)
                      : $urandom_range(0, 45);
            step($urandom_range(0, 7), $urandom_range(0, 45), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 4) == 0) ? 2 : 0, ($urandom_range(0, 4) == 0) ? 6 : 0,
                 $urandom_range(0, 5), wo, ($urandom_range(0, 3) != 0), oct,
                 {2'($urandom), $urandom}, "R2/R6 mixed");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule